// File: doc/BRIEF.md
# Condition Test and Loop Branch Unit

This unit decides whether a branch is taken. It reads a four-bit condition code and the four arithmetic flags (negative, zero, overflow, carry) and evaluates one of sixteen tests. Fourteen of the tests are real flag tests. One code is always true. The remaining code would mean "never". In the branch family, that code is used as a call instead: the branch is always taken, and the unit also requests a push of the return address. Target address generation and fetch are handled elsewhere.

The unit also handles the counted-loop primitive. In loop mode, a true condition ends the loop at once: nothing is decremented and the branch falls through. A false condition has three effects:
- Only the low half-word of the supplied 32-bit register is decremented.
- The upper half-word is written back unchanged.
- The branch is taken unless the new low half-word equals 0xFFFF.

Using -1 as the end value lets a loop with a starting count of zero run the expected number of times. Each request is registered, and its result appears one cycle later with a valid strobe.

Top module: `cond_loop_unit`

## Requirements
- R1: During reset and in the first cycle after it, `res_valid`, `take`, `wb_en` and `push_ret` are 0. A request accepted with `op_valid` at a clock edge produces its result, with `res_valid` high, after the next edge.
- R2: When `loop_mode`=0 and `cond_sel`=0 (always true), `take`=1 and `push_ret`=0 for any flags.
- R3: When `loop_mode`=0 and `cond_sel`=1, the call code applies: `take`=1 and `push_ret`=1 for any flags.
- R4: The flags are `flags[3]`=N, `flags[2]`=Z, `flags[1]`=V, `flags[0]`=C. The single-flag codes are 4 (!C), 5 (C), 6 (!Z), 7 (Z), 8 (!V), 9 (V), 10 (!N) and 11 (N).
- R5: The unsigned codes are 2 (higher: !C & !Z) and 3 (lower-or-same: C | Z).
- R6: The signed codes are 12 (N==V), 13 (N!=V), 14 (!Z & N==V) and 15 (Z | N!=V).
- R7: When `loop_mode`=1 and the condition is true, `take`=0 and `wb_en`=0.
- R8: When `loop_mode`=1 and the condition is false:
  - `wb_en`=1;
  - `wb_data[15:0]` is the input low half minus 1, modulo 2^16;
  - `wb_data[31:16]` equals the input upper half.
- R9: In a loop step that decrements, `take`=1 exactly when the new low half is not 0xFFFF, so a starting low half of 0 is not taken.
- R10: When `loop_mode`=1, code 1 counts as false and always decrements, code 0 never decrements, and `push_ret` is always 0.
- R11: A cycle with `op_valid`=0 gives `res_valid`=0, `take`=0, `wb_en`=0, `push_ret`=0 and `wb_data`=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request present this cycle |
| loop_mode | input | 1 | 0: branch family, 1: decrement-and-branch |
| cond_sel | input | 4 | Condition code |
| flags | input | 4 | N, Z, V, C (bits 3 to 0) |
| reg_in | input | 32 | Loop counter register value |
| res_valid | output | 1 | Result valid |
| take | output | 1 | Branch taken |
| wb_en | output | 1 | Register write-back enable |
| wb_data | output | 32 | Register write-back value |
| push_ret | output | 1 | Return-address push request |

## Verification
In loop mode, a decrement and the loop exit can fall in the same result. This happens when a false condition meets a low half of zero: the write-back must still carry 0xFFFF while `take` drops. The bench sets this up directly with low halves of 0 and 1 under always-false, and it also lets random counts near those values occur. The same check covers every false condition code, and random upper halves confirm the decrement never spills into bit 16.

// File: rtl/cond_loop_unit.sv
module cond_loop_unit #(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             loop_mode,
  input  logic [3:0]       cond_sel,
  input  logic [3:0]       flags,
  input  logic [REG_W-1:0] reg_in,
  output logic             res_valid,
  output logic             take,
  output logic             wb_en,
  output logic [REG_W-1:0] wb_data,
  output logic             push_ret
);
  localparam logic [CNT_W-1:0] END_CNT = '1;

  logic n_f, z_f, v_f, c_f, cond_true;
  assign {n_f, z_f, v_f, c_f} = flags;

  always_comb begin
    unique case (cond_sel)
      4'd0:  cond_true = 1'b1;
      4'd1:  cond_true = 1'b0;
      4'd2:  cond_true = !c_f && !z_f;
      4'd3:  cond_true = c_f || z_f;
      4'd4:  cond_true = !c_f;
      4'd5:  cond_true = c_f;
      4'd6:  cond_true = !z_f;
      4'd7:  cond_true = z_f;
      4'd8:  cond_true = !v_f;
      4'd9:  cond_true = v_f;
      4'd10: cond_true = !n_f;
      4'd11: cond_true = n_f;
      4'd12: cond_true = n_f ~^ v_f;
      4'd13: cond_true = n_f ^ v_f;
      4'd14: cond_true = !z_f && (n_f ~^ v_f);
      default: cond_true = z_f || (n_f ^ v_f);
    endcase
  end

  logic [CNT_W-1:0] next_cnt;
  logic             call_code, dec_now, take_d;
  assign next_cnt  = reg_in[CNT_W-1:0] - 1'b1;
  assign call_code = !loop_mode && cond_sel == 4'd1;
  assign dec_now   = loop_mode && !cond_true;
  assign take_d    = loop_mode ? (dec_now && next_cnt != END_CNT) : (cond_true || call_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      take      <= 1'b0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
      push_ret  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      take      <= op_valid && take_d;
      wb_en     <= op_valid && dec_now;
      wb_data   <= op_valid ? {reg_in[REG_W-1:CNT_W], (dec_now ? next_cnt : reg_in[CNT_W-1:0])} : '0;
      push_ret  <= op_valid && call_code;
    end
  end
endmodule

module cond_loop_unit_chk #(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             loop_mode,
  input logic [3:0]       cond_sel,
  input logic [REG_W-1:0] reg_in,
  input logic             res_valid,
  input logic             take,
  input logic             wb_en,
  input logic [REG_W-1:0] wb_data,
  input logic             push_ret
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!take && !wb_en && !push_ret));
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_valid == $past(op_valid)));
  assert_call_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret |-> (take && !wb_en));
  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[REG_W-1:CNT_W] == $past(reg_in[REG_W-1:CNT_W])));
  assert_low_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[CNT_W-1:0] == CNT_W'($past(reg_in[CNT_W-1:0]) - 1'b1)));
  assert_exit_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_data[CNT_W-1:0] == '1) |-> !take);
  assert_loop_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode) |=> !push_ret);
  assert_loop_never_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode && cond_sel == 4'd1) |=> wb_en);
endmodule

bind cond_loop_unit cond_loop_unit_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .loop_mode(loop_mode),
  .cond_sel(cond_sel), .reg_in(reg_in), .res_valid(res_valid), .take(take),
  .wb_en(wb_en), .wb_data(wb_data), .push_ret(push_ret));

// File: tb/cond_loop_unit_tb_top.sv
module cond_loop_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, loop_mode = 1'b0;
  logic [3:0] cond_sel = '0, flags = '0;
  logic [31:0] reg_in = '0;
  logic res_valid, take, wb_en, push_ret;
  logic [31:0] wb_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cond_loop_unit dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .loop_mode(loop_mode),
    .cond_sel(cond_sel), .flags(flags), .reg_in(reg_in), .res_valid(res_valid), .take(take),
    .wb_en(wb_en), .wb_data(wb_data), .push_ret(push_ret));

  function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], v = f[1], cy = f[0];
    case (c)
      0: return 1; 1: return 0; 2: return !cy && !z; 3: return cy || z;
      4: return !cy; 5: return cy; 6: return !z; 7: return z;
      8: return !v; 9: return v; 10: return !n; 11: return n;
      12: return n == v; 13: return n != v; 14: return !z && n == v;
      default: return z || n != v;
    endcase
  endfunction

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input bit v, input bit lm, input logic [3:0] c,
                     input logic [3:0] f, input logic [31:0] r);
    logic [31:0] ed; bit et, ew, ep, ct; logic [15:0] nl;
    @(negedge clk);
    op_valid = v; loop_mode = lm; cond_sel = c; flags = f; reg_in = r;
    ct = ref_cond(c, f); nl = r[15:0] - 16'd1;
    if (!v) begin et = 0; ew = 0; ep = 0; ed = '0; end
    else if (!lm) begin et = ct || c == 1; ew = 0; ep = (c == 1); ed = r; end
    else begin ew = !ct; ep = 0; et = !ct && nl != 16'hFFFF; ed = ct ? r : {r[31:16], nl}; end
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, {res_valid, take, wb_en, push_ret, 31'(0)} | 35'(wb_data), {v, et, ew, ep, 31'(0)} | 35'(ed));
  endtask

  initial begin
    #2_000_000; fails++; $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails); $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset", {res_valid, take, wb_en, push_ret}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset", {res_valid, take, wb_en, push_ret}, 4'b0);
    for (int f = 0; f < 16; f++) begin
      run("R2 always", 1, 0, 4'd0, 4'(f), 32'h1234_5678);
      run("R3 call", 1, 0, 4'd1, 4'(f), 32'h0);
      for (int c = 2; c < 16; c++)
        run(c < 4 ? "R5 unsigned" : (c < 12 ? "R4 single" : "R6 signed"), 1, 0, 4'(c), 4'(f), 32'hA5A5_0003);
    end
    run("R7 loop true", 1, 1, 4'd7, 4'b0100, 32'h0000_0005);
    run("R7 loop always", 1, 1, 4'd0, 4'b0000, 32'h0000_0000);
    run("R8 loop dec", 1, 1, 4'd7, 4'b0000, 32'hBEEF_0005);
    run("R9 exit at zero", 1, 1, 4'd1, 4'b0000, 32'h7777_0000);
    run("R9 last iteration", 1, 1, 4'd1, 4'b0000, 32'h7777_0001);
    run("R8 no borrow", 1, 1, 4'd1, 4'b1111, 32'hFFFF_0000);
    run("R10 counted loop", 1, 1, 4'd1, 4'b1111, 32'h0001_FFFF);
    run("R11 idle", 0, 1, 4'd1, 4'b0000, 32'h1111_2222);
    run("R11 idle branch", 0, 0, 4'd0, 4'b0000, 32'h1111_2222);
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r = $urandom;
      if ($urandom_range(3) == 0) r[15:0] = 16'($urandom_range(2));
      run("R7 R8 R9 R10 R11 random", $urandom_range(7) != 0, 1'($urandom), 4'($urandom), 4'($urandom), r);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule